// File: doc/BRIEF.md
# Watermark Memory Privilege Checker

This block sits in front of one on-chip memory and decides, transaction by transaction, whether an access may proceed. Two length registers split the memory into three zones, each starting at the memory base. The first zone is writable by unprivileged masters. The second zone is readable and executable by unprivileged masters but not writable by them. Everything above the outer length is privileged only. Each length counts granules of `GRAN_BYTES`. The writable length only takes effect inside the unprivileged zone.

The checker also enforces the security attribute of the memory, which comes from a strap input. A non-secure master may not touch a secure memory. A secure master may not fetch code from a non-secure memory. When the security-enable input is low, every access is granted and the length registers are inert.

Each request is a single cycle. The checker registers its answer and presents it one cycle later as a grant, or as an illegal-access event together with a bus error. Read data from the memory is forwarded only on a grant. The length registers have their own single-cycle write port and a combinational read-back. Writes to that port follow lock and attribute rules.

Top module: `wm_priv_checker`

## Requirements
- R1: After reset both length registers read 0x0FFF0000, and an unprivileged write anywhere in the memory is granted.
- R2: A length occupies bits 27:16 of its register. Reserved bits are dropped on write and read as zero. `cfg_sel`=0 selects the unprivileged length and `cfg_sel`=1 selects the writable length, for both write and read.
- R3: Granule index = offset / `GRAN_BYTES`. An offset lies in the unprivileged zone when its granule index is below the stored length, with any stored length of 0x800 or more treated as 0x800. A length of 0 leaves no unprivileged zone. A length at or above the granule count covers the whole memory.
- R4: An unprivileged write is legal only where the offset lies in both the unprivileged zone and the writable zone. An unprivileged read or fetch inside the unprivileged zone is legal even outside the writable zone.
- R5: With security enabled, any unprivileged fetch, read or write outside the unprivileged zone is illegal.
- R6: Privileged transactions are legal at every offset, subject only to R7.
- R7: With security enabled, any access by a non-secure master to memory strapped secure is illegal. A fetch by a secure master to memory strapped non-secure is illegal. Secure reads and writes to non-secure memory are legal. `req_kind` encodings: 00 fetch, 01 read, 1x write.
- R8: With `sec_en` low, every access is granted, whatever the lengths. The registers can still be written and read back.
- R9: A register write takes effect only when `cfg_lock` is low and the writer is privileged. If the memory is strapped secure, the writer must also be secure. Any other write leaves the register unchanged.
- R10: The response appears in the cycle after `req_valid`. An illegal access asserts `rsp_event` and `rsp_error`, deasserts `rsp_grant` and returns zero data. A granted access returns the `mem_rdata` value presented with the request. The event lasts exactly one cycle per offending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_en | input | 1 | System security enable |
| mem_secure | input | 1 | Strap: memory is secure |
| cfg_lock | input | 1 | Blocks all length register writes |
| cfg_wr | input | 1 | Length register write strobe |
| cfg_sel | input | 1 | 0 = unprivileged length, 1 = writable length |
| cfg_wdata | input | 32 | Register write data |
| cfg_priv | input | 1 | Register writer is privileged |
| cfg_secure | input | 1 | Register writer is secure |
| cfg_rdata | output | 32 | Read-back of the selected register |
| req_valid | input | 1 | Memory request present |
| req_offset | input | ADDR_W (18) | Byte offset from memory base |
| req_kind | input | 2 | 00 fetch, 01 read, 1x write |
| req_priv | input | 1 | Requester privileged |
| req_secure | input | 1 | Requester secure |
| mem_rdata | input | 32 | Data from the memory for this request |
| rsp_valid | output | 1 | Response present |
| rsp_grant | output | 1 | Access granted |
| rsp_event | output | 1 | Illegal-access event pulse |
| rsp_error | output | 1 | Bus error |
| rsp_rdata | output | 32 | Response data, zero unless granted |

## Verification
A corrupted length register shows up at once on `cfg_rdata`. It also shows up one cycle after the first request that probes the moved boundary, as a grant where an event was expected or the reverse. That is why the bench probes the granules on each side of every programmed boundary. A wrong zone comparison or a wrong attribute decode likewise shows up in the response cycle that follows the offending request. A stuck response register shows up as an event lasting into an idle cycle, or as non-zero data returned with an event.

// File: rtl/wm_priv_checker.sv
module wm_priv_checker #(
  parameter int MEM_BYTES  = 262144,
  parameter int GRAN_BYTES = 2048,
  parameter int LEN_W      = 12,
  parameter int LEN_LSB    = 16,
  parameter int DATA_W     = 32,
  parameter logic [LEN_W-1:0] LEN_CAP = 12'h800,
  localparam int ADDR_W    = $clog2(MEM_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_en,
  input  logic              mem_secure,
  input  logic              cfg_lock,
  input  logic              cfg_wr,
  input  logic              cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              cfg_priv,
  input  logic              cfg_secure,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_offset,
  input  logic [1:0]        req_kind,
  input  logic              req_priv,
  input  logic              req_secure,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              rsp_valid,
  output logic              rsp_grant,
  output logic              rsp_event,
  output logic              rsp_error,
  output logic [DATA_W-1:0] rsp_rdata
);
  localparam int GRAN_SH = $clog2(GRAN_BYTES);
  localparam logic [LEN_W-1:0] LEN_RST = '1;

  logic [LEN_W-1:0] up_len, wr_len, up_eff, wr_eff, gidx;
  logic cfg_ok, in_up, in_wr, is_fetch, is_write, sec_bad, priv_bad, illegal;

  assign cfg_ok = cfg_wr && !cfg_lock && cfg_priv && (!mem_secure || cfg_secure);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_len <= LEN_RST;
      wr_len <= LEN_RST;
    end else if (cfg_ok) begin
      if (cfg_sel) wr_len <= cfg_wdata[LEN_LSB +: LEN_W];
      else         up_len <= cfg_wdata[LEN_LSB +: LEN_W];
    end
  end

  always_comb begin
    cfg_rdata = '0;
    cfg_rdata[LEN_LSB +: LEN_W] = cfg_sel ? wr_len : up_len;
  end

  assign up_eff   = (up_len > LEN_CAP) ? LEN_CAP : up_len;
  assign wr_eff   = (wr_len > LEN_CAP) ? LEN_CAP : wr_len;
  assign gidx     = LEN_W'(req_offset[ADDR_W-1:GRAN_SH]);
  assign in_up    = gidx < up_eff;
  assign in_wr    = in_up && (gidx < wr_eff);
  assign is_fetch = (req_kind == 2'b00);
  assign is_write = req_kind[1];

  assign sec_bad  = (mem_secure && !req_secure) || (!mem_secure && req_secure && is_fetch);
  assign priv_bad = !req_priv && (!in_up || (is_write && !in_wr));
  assign illegal  = sec_en && (sec_bad || priv_bad);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_grant <= 1'b0;
      rsp_event <= 1'b0;
      rsp_error <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_grant <= req_valid && !illegal;
      rsp_event <= req_valid && illegal;
      rsp_error <= req_valid && illegal;
      rsp_rdata <= (req_valid && !illegal) ? mem_rdata : '0;
    end
  end

  assert_illegal_response_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_event |-> (rsp_error && !rsp_grant && rsp_valid && rsp_rdata == '0));

  assert_event_needs_request_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_event);

  assert_lock_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_lock |=> ($stable(up_len) && $stable(wr_len)));

  assert_security_off_grants_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !sec_en) |=> rsp_grant);

  assert_privileged_matched_grants_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_priv && (req_secure == mem_secure)) |=> rsp_grant);

  assert_unpriv_write_room_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && sec_en && !req_priv && is_write && !(gidx < wr_eff)) |=> rsp_event);
endmodule

// File: tb/wm_priv_checker_bench.sv
module wm_priv_checker_bench;
  localparam int AW = 18;
  localparam int GB = 2048;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sec_en = 1'b1, mem_secure = 1'b0, cfg_lock = 1'b0, cfg_wr = 1'b0, cfg_sel = 1'b0;
  logic [31:0] cfg_wdata = '0, cfg_rdata, mem_rdata = '0, rsp_rdata;
  logic cfg_priv = 1'b0, cfg_secure = 1'b0;
  logic req_valid = 1'b0, req_priv = 1'b0, req_secure = 1'b0;
  logic [AW-1:0] req_offset = '0;
  logic [1:0] req_kind = 2'b00;
  logic rsp_valid, rsp_grant, rsp_event, rsp_error;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wm_priv_checker u_wm_priv_checker (
    .clk(clk), .rst_n(rst_n), .sec_en(sec_en), .mem_secure(mem_secure), .cfg_lock(cfg_lock),
    .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_priv(cfg_priv),
    .cfg_secure(cfg_secure), .cfg_rdata(cfg_rdata), .req_valid(req_valid), .req_offset(req_offset),
    .req_kind(req_kind), .req_priv(req_priv), .req_secure(req_secure), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_event(rsp_event), .rsp_error(rsp_error),
    .rsp_rdata(rsp_rdata));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg(logic sel, logic [31:0] d, logic p, logic s);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d; cfg_priv = p; cfg_secure = s;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic readback(string tag, logic sel, logic [31:0] exp);
    @(negedge clk);
    cfg_sel = sel;
    #0.1;
    chk(tag, cfg_rdata, exp);
  endtask

  // expect_ok: 1 = granted, 0 = illegal
  task automatic access(string tag, int gran, logic [1:0] kind, logic p, logic s, logic expect_ok);
    logic [31:0] d;
    d = 32'hA5000000 + 32'(gran);
    @(negedge clk);
    req_valid = 1'b1; req_offset = AW'(gran * GB + 4); req_kind = kind;
    req_priv = p; req_secure = s; mem_rdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk(tag, {rsp_valid, rsp_grant, rsp_event, rsp_error}, {1'b1, expect_ok, !expect_ok, !expect_ok});
    chk({tag, " data"}, rsp_rdata, expect_ok ? d : 32'h0);
  endtask

  task automatic t_reset;
    chk("R1 rsp idle at reset", {28'h0, rsp_valid, rsp_grant, rsp_event, rsp_error}, 32'h0);
    readback("R1 unpriv len reset", 1'b0, 32'h0FFF0000);
    readback("R1 writable len reset", 1'b1, 32'h0FFF0000);
    access("R1 unpriv write top granule", 127, 2'b10, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_zones;
    cfg(1'b0, 32'hF004ABCD, 1'b1, 1'b0);
    cfg(1'b1, 32'h0002FFFF, 1'b1, 1'b0);
    readback("R2 unpriv len field", 1'b0, 32'h00040000);
    readback("R2 writable len field", 1'b1, 32'h00020000);
    access("R4 unpriv write in writable", 1, 2'b10, 1'b0, 1'b0, 1'b1);
    access("R4 unpriv write above writable", 2, 2'b10, 1'b0, 1'b0, 1'b0);
    access("R4 unpriv read in ro zone", 3, 2'b01, 1'b0, 1'b0, 1'b1);
    access("R4 unpriv fetch in ro zone", 3, 2'b00, 1'b0, 1'b0, 1'b1);
    access("R5 unpriv read priv zone", 4, 2'b01, 1'b0, 1'b0, 1'b0);
    access("R5 unpriv fetch priv zone", 5, 2'b00, 1'b0, 1'b0, 1'b0);
    access("R6 priv write priv zone", 10, 2'b10, 1'b1, 1'b0, 1'b1);
    @(negedge clk);
    chk("R10 event one cycle", {31'h0, rsp_event}, 32'h0);
  endtask

  task automatic t_bounds;
    cfg(1'b0, 32'h007F0000, 1'b1, 1'b0);
    cfg(1'b1, 32'h09000000, 1'b1, 1'b0);
    access("R3 last granule inside len", 126, 2'b10, 1'b0, 1'b0, 1'b1);
    access("R3 granule equal len", 127, 2'b01, 1'b0, 1'b0, 1'b0);
    cfg(1'b0, 32'h09000000, 1'b1, 1'b0);
    readback("R3 oversized len stored", 1'b0, 32'h09000000);
    access("R3 oversized len covers all", 127, 2'b10, 1'b0, 1'b0, 1'b1);
    cfg(1'b0, 32'h00000000, 1'b1, 1'b0);
    access("R3 zero len granule0", 0, 2'b01, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_security;
    cfg(1'b0, 32'h00800000, 1'b1, 1'b0);
    access("R7 secure fetch nonsecure mem", 0, 2'b00, 1'b1, 1'b1, 1'b0);
    access("R7 secure read nonsecure mem", 0, 2'b01, 1'b1, 1'b1, 1'b1);
    mem_secure = 1'b1;
    access("R7 nonsecure read secure mem", 0, 2'b01, 1'b1, 1'b0, 1'b0);
    access("R7 secure write secure mem", 0, 2'b10, 1'b1, 1'b1, 1'b1);
  endtask

  task automatic t_cfg_rules;
    cfg(1'b0, 32'h00100000, 1'b1, 1'b0);
    readback("R9 nonsecure write to secure mem ignored", 1'b0, 32'h00800000);
    cfg(1'b0, 32'h00100000, 1'b0, 1'b1);
    readback("R9 unpriv write ignored", 1'b0, 32'h00800000);
    cfg_lock = 1'b1;
    cfg(1'b0, 32'h00100000, 1'b1, 1'b1);
    readback("R9 locked write ignored", 1'b0, 32'h00800000);
    cfg_lock = 1'b0;
    cfg(1'b0, 32'h00100000, 1'b1, 1'b1);
    readback("R9 secure priv write accepted", 1'b0, 32'h00100000);
    mem_secure = 1'b0;
  endtask

  task automatic t_sec_off;
    sec_en = 1'b0;
    access("R8 unpriv write priv zone granted", 100, 2'b10, 1'b0, 1'b0, 1'b1);
    access("R8 secure fetch granted", 100, 2'b00, 1'b0, 1'b1, 1'b1);
    cfg(1'b1, 32'h00050000, 1'b1, 1'b0);
    readback("R8 reg still writable", 1'b1, 32'h00050000);
    sec_en = 1'b1;
    access("R5 security back on", 100, 2'b01, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_zones;
    t_bounds;
    t_security;
    t_cfg_rules;
    t_sec_off;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule